// File: doc/BRIEF.md
# Residue-Checked Integer Multiplier

This block multiplies two 16-bit unsigned operands into a 32-bit product and checks that product concurrently with an independent residue path. The predictor reduces each operand modulo m = 2^k − 1 and multiplies the two small residues. It then reduces that result again. The product's own residue is formed from the same 32-bit word that leaves the block. The two residues are compared, and any difference raises an error flag. The same residue follows from both paths because (a·b) mod m equals ((a mod m)·(b mod m)) mod m.

The modulus is fixed at elaboration and may be 3, 7 or 15. A larger modulus catches more faults for a few more gates: roughly two faults in three at 3, close to nine in ten at 7 and above nine in ten at 15. All residues are computed by adding k-bit slices of a word with end-around carry, and the all-ones value is folded to zero. A fault-injection mask XORs into the product net just after the multiplier array. This lets test hardware corrupt the result in the same place a physical fault would. An optional register stage captures the product and the flag on the same edge.

Top module: `resmul_chk`

## Requirements
- R1: With a zero fault mask, `prod_o` equals `opa_i × opb_i` as a 32-bit unsigned value for every operand pair.
- R2: The parameter `MODULUS` selects m. Its default is 7, and only 3, 7 and 15 elaborate. With an all-zero product and a fault mask of 7, the flag stays low for m = 7 and rises for m = 15.
- R3: `err_o` is 1 exactly when (product after fault injection) mod m differs from ((opa_i mod m)·(opb_i mod m)) mod m. Both residues lie in 0..m−1.
- R4: With `flt_xor_i` = 0, `err_o` stays 0 for every operand pair.
- R5: Any fault mask with exactly one bit set raises `err_o`, whatever the operands.
- R6: With `OUT_REG` = 1, the product and the flag appear together one rising edge after the operands. The active-low `rst_ni` clears both to 0. With `OUT_REG` = 0 both outputs are combinational.
- R7: Bit i of `flt_xor_i` inverts bit i of the product. The inverted product is both driven on `prod_o` and checked.
- R8: A fault that changes the product by a multiple of m leaves `err_o` at 0. For example, mask 0x7 on a zero product is not flagged for m = 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output stage |
| rst_ni | input | 1 | Asynchronous active-low reset |
| opa_i | input | 16 | Multiplicand, unsigned |
| opb_i | input | 16 | Multiplier, unsigned |
| flt_xor_i | input | 32 | Fault mask XORed into the raw product |
| prod_o | output | 32 | Product, possibly corrupted by the mask |
| err_o | output | 1 | Residue mismatch flag |

## Verification
A corrupted partial-product row or adder carry shows up as a wrong `prod_o` at the first edge after the operands. The residue comparison on the same edge usually shows it as well. A faulty slice adder or a missing zero fold in a residue generator instead raises `err_o` spuriously on fault-free operand pairs. It can also leave the flag low for a single-bit flip. The long fault-free sweep and the per-bit flip sweep expose both cases within one operand pair of the first one affected. A mis-timed output stage separates the flag from its product by a cycle. The bench catches this on the first vector that changes the flag.

// File: rtl/resmul_pkg.sv
package resmul_pkg;
   localparam int unsigned OPW_DEF = 16;

   function automatic bit mod_legal(input int unsigned m);
      return (m == 3) || (m == 7) || (m == 15);
   endfunction

   function automatic int unsigned mod_bits(input int unsigned m);
      return (m == 3) ? 2 : (m == 7) ? 3 : 4;
   endfunction
endpackage

// File: rtl/resmul_modred.sv
module resmul_modred #(
   parameter int unsigned W = 32,
   parameter int unsigned K = 3
) (
   input  logic [W-1:0] val_i,
   output logic [K-1:0] res_o
);
   localparam int unsigned N  = (W + K - 1) / K;
   localparam int unsigned PW = N * K;
   localparam int unsigned SW = K + $clog2(N + 1);

   logic [PW-1:0] padded;
   logic [SW-1:0] acc;

   assign padded = PW'(val_i);

   always_comb begin
      acc = '0;
      for (int i = 0; i < N; i++) begin
         acc = acc + SW'(padded[i*K +: K]);
      end
      for (int f = 0; f < SW; f++) begin
         acc = SW'(acc[K-1:0]) + (acc >> K);
      end
      res_o = (acc[K-1:0] == {K{1'b1}}) ? '0 : acc[K-1:0];
   end
endmodule

// File: rtl/resmul_array.sv
module resmul_array #(
   parameter int unsigned AW = 16,
   parameter int unsigned BW = 16
) (
   input  logic [AW-1:0]    opa_i,
   input  logic [BW-1:0]    opb_i,
   output logic [AW+BW-1:0] prod_o
);
   localparam int unsigned PW = AW + BW;

   logic [PW-1:0] acc [BW+1];

   assign acc[0] = '0;

   for (genvar g = 0; g < BW; g++) begin : g_row
      logic [PW-1:0] row;
      assign row        = opb_i[g] ? (PW'(opa_i) << g) : '0;
      assign acc[g + 1] = acc[g] + row;
   end

   assign prod_o = acc[BW];
endmodule

// File: rtl/resmul_respred.sv
module resmul_respred #(
   parameter int unsigned OPW = 16,
   parameter int unsigned K   = 3
) (
   input  logic [OPW-1:0] opa_i,
   input  logic [OPW-1:0] opb_i,
   output logic [K-1:0]   res_o
);
   logic [K-1:0]   ra;
   logic [K-1:0]   rb;
   logic [2*K-1:0] rprod;

   resmul_modred #(.W(OPW), .K(K)) u_red_a (.val_i(opa_i), .res_o(ra));
   resmul_modred #(.W(OPW), .K(K)) u_red_b (.val_i(opb_i), .res_o(rb));

   assign rprod = (2*K)'(ra) * (2*K)'(rb);

   resmul_modred #(.W(2*K), .K(K)) u_red_p (.val_i(rprod), .res_o(res_o));
endmodule

// File: rtl/resmul_chk.sv
module resmul_chk #(
   parameter int unsigned OPW     = resmul_pkg::OPW_DEF,
   parameter int unsigned MODULUS = 7,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [OPW-1:0]   opa_i,
   input  logic [OPW-1:0]   opb_i,
   input  logic [2*OPW-1:0] flt_xor_i,
   output logic [2*OPW-1:0] prod_o,
   output logic             err_o
);
   localparam int unsigned PW = 2 * OPW;
   localparam int unsigned K  = resmul_pkg::mod_bits(MODULUS);

   if (!resmul_pkg::mod_legal(MODULUS)) begin : g_bad_mod
      $error("resmul_chk: MODULUS must be 3, 7 or 15");
   end
   if (OPW < 2) begin : g_bad_width
      $error("resmul_chk: OPW must be at least 2");
   end

   logic [PW-1:0] prod_raw;
   logic [PW-1:0] prod_flt;
   logic [K-1:0]  res_act;
   logic [K-1:0]  res_pred;
   logic          err_comb;

   resmul_array #(.AW(OPW), .BW(OPW)) u_array (
      .opa_i (opa_i),
      .opb_i (opb_i),
      .prod_o(prod_raw)
   );

   assign prod_flt = prod_raw ^ flt_xor_i;

   resmul_modred #(.W(PW), .K(K)) u_red_prod (
      .val_i(prod_flt),
      .res_o(res_act)
   );

   resmul_respred #(.OPW(OPW), .K(K)) u_pred (
      .opa_i(opa_i),
      .opb_i(opb_i),
      .res_o(res_pred)
   );

   assign err_comb = (res_act != res_pred);

   if (OUT_REG) begin : g_oreg
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            prod_o <= '0;
            err_o  <= 1'b0;
         end else begin
            prod_o <= prod_flt;
            err_o  <= err_comb;
         end
      end

      // R6: product and flag launch together on one edge
      a_r6_reg_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
         1'b1 |=> (prod_o == $past(prod_flt)) && (err_o == $past(err_comb)));
   end else begin : g_comb
      assign prod_o = prod_flt;
      assign err_o  = err_comb;
   end

   // R1: shift-add array agrees with arithmetic product
   a_r1_product: assert property (@(posedge clk_i) disable iff (!rst_ni)
      prod_raw == (PW'(opa_i) * PW'(opb_i)));

   // R3: both residues are in canonical range 0..m-1
   a_r3_res_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int'(res_act) < MODULUS) && (int'(res_pred) < MODULUS));

   // R4: no fault, no flag
   a_r4_no_false_alarm: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flt_xor_i == '0) |-> !err_comb);

   // R5: any single-bit flip is flagged
   a_r5_single_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($countones(flt_xor_i) == 1) |-> err_comb);
endmodule

// File: tb/resmul_chk_tb.sv
`timescale 1ns/1ps
module resmul_chk_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] opa = '0;
   logic [15:0] opb = '0;
   logic [31:0] flt = '0;
   logic [31:0] prod7, prod15;
   logic        err7, err15;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   resmul_chk #(.OPW(16), .MODULUS(7), .OUT_REG(1'b1)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .opa_i(opa), .opb_i(opb),
      .flt_xor_i(flt), .prod_o(prod7), .err_o(err7));

   resmul_chk #(.OPW(16), .MODULUS(15), .OUT_REG(1'b0)) u_dut15 (
      .clk_i(clk), .rst_ni(rst_n), .opa_i(opa), .opb_i(opb),
      .flt_xor_i(flt), .prod_o(prod15), .err_o(err15));

   // {opa, opb, fault mask}
   localparam logic [63:0] VEC [0:11] = '{
      {16'h0000, 16'h0000, 32'h0000_0000},
      {16'h0001, 16'h0001, 32'h0000_0000},
      {16'hFFFF, 16'hFFFF, 32'h0000_0000},
      {16'h1234, 16'h5678, 32'h0000_0000},
      {16'hFFFF, 16'h0001, 32'h0000_0000},
      {16'h8000, 16'h0002, 32'h0000_0000},
      {16'h00FF, 16'hFF00, 32'h0000_0000},
      {16'h1234, 16'h5678, 32'h0000_0001},
      {16'h0003, 16'h0005, 32'h8000_0000},
      {16'hABCD, 16'h0000, 32'h0000_000F},
      {16'h0007, 16'h0009, 32'h0001_0001},
      {16'hFFFF, 16'hFFFF, 32'hFFFF_FFFF}
   };

   function automatic logic [31:0] exp_prod(input logic [15:0] a, input logic [15:0] b,
                                           input logic [31:0] f);
      return (32'(a) * 32'(b)) ^ f;
   endfunction

   function automatic logic exp_err(input logic [15:0] a, input logic [15:0] b,
                                    input logic [31:0] f, input int m);
      longint p;
      longint q;
      p = longint'(exp_prod(a, b, f));
      q = (longint'(a) % m) * (longint'(b) % m);
      return (p % m) != (q % m);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   // drive at negedge; registered outputs valid at the following negedge
   task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic [31:0] f);
      @(negedge clk);
      opa = a;
      opb = b;
      flt = f;
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : stim
      logic [31:0] x;
      int          bad4;
      int          bad5;

      // R6: reset clears registered outputs
      repeat (3) @(negedge clk);
      check("R6 reset prod", prod7, 32'h0);
      check("R6 reset err", {31'b0, err7}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // vector table
      for (int i = 0; i < 12; i++) begin
         logic [15:0] a;
         logic [15:0] b;
         logic [31:0] f;
         {a, b, f} = VEC[i];
         apply(a, b, f);
         check("R1/R7 prod m7", prod7, exp_prod(a, b, f));
         check("R3 err m7", {31'b0, err7}, {31'b0, exp_err(a, b, f, 7)});
         check("R1/R7 prod m15", prod15, exp_prod(a, b, f));
         check("R3 err m15", {31'b0, err15}, {31'b0, exp_err(a, b, f, 15)});
      end

      // R2 / R8: mask 7 on zero product hides from m=7 but not m=15
      apply(16'h0000, 16'h1111, 32'h0000_0007);
      check("R8 undetected m7", {31'b0, err7}, 32'h0);
      check("R2 modulus 15 flags", {31'b0, err15}, 32'h1);

      // R8: change by 15 hides from m=15
      apply(16'h0000, 16'h0000, 32'h0000_000F);
      check("R8 undetected m15", {31'b0, err15}, 32'h0);

      // R6: registered output holds until the edge, combinational follows at once
      apply(16'h0002, 16'h0003, 32'h0);
      @(negedge clk);
      opa = 16'h0005;
      opb = 16'h0005;
      #1;
      check("R6 reg holds before edge", prod7, 32'd6);
      check("R6 comb follows", prod15, 32'd25);
      @(negedge clk);
      check("R6 reg after edge", prod7, 32'd25);

      // R4: fault-free sweep, flag must stay low
      x = 32'h1357_9BDF;
      bad4 = 0;
      for (int n = 0; n < 3000; n++) begin
         x = x ^ (x << 13);
         x = x ^ (x >> 17);
         x = x ^ (x << 5);
         apply(x[31:16], x[15:0], 32'h0);
         if (err7 !== 1'b0 || err15 !== 1'b0 || prod7 !== exp_prod(x[31:16], x[15:0], 32'h0))
            bad4++;
      end
      check("R4 fault-free sweep mismatches", 32'(bad4), 32'h0);

      // R5: every single-bit flip is caught, for both moduli
      bad5 = 0;
      for (int j = 0; j < 32; j++) begin
         apply(16'hBEEF, 16'h1234 + 16'(j), 32'h1 << j);
         if (err7 !== 1'b1 || err15 !== 1'b1) bad5++;
         if (prod15 !== exp_prod(16'hBEEF, 16'h1234 + 16'(j), 32'h1 << j)) bad5++;
      end
      check("R5 single-bit flips missed", 32'(bad5), 32'h0);

      // R6: reset mid-run clears registered outputs
      apply(16'hFFFF, 16'hFFFF, 32'h1);
      #1;
      rst_n = 1'b0;
      #1;
      check("R6 async reset prod", prod7, 32'h0);
      check("R6 async reset err", {31'b0, err7}, 32'h0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule